// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transceiver

This block gives a processor an 8-bit register window onto one asynchronous serial line. A select input and read/write strobes reach either the data path or the command/status pair, chosen by a control/data line. Bytes written to the data path wait in a holding register. Each one then moves into a shift register that sends it as a frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The receiver watches the incoming line on a 16x oversampled tick, rebuilds each frame in a shift register and hands the byte to a receive buffer.

The transmitter keeps two flags. Ready says the holding register is free. Empty says the shift register is idle as well. So software can queue the next byte while the current one is still on the wire. The command register drives two active-low modem outputs and gates the transmitter. Status reports the flags, receive errors and the modem inputs.

Top module: `sio_xcvr`

## Requirements
- R1: After reset, txd is 1, tx_rdy is 1, tx_empty is 1, rx_rdy is 0, and dtr_n and rts_n are both 1.
- R2: While cs_n is 1, writes change nothing and dout is 0.
- R3: A write with cd_sel=1 loads the command register. Command bit 1 set drives dtr_n low and bit 5 set drives rts_n low. A read with cd_sel=1 returns status: bit0 tx_rdy, bit1 rx_rdy, bit2 tx_empty, bit4 overrun, bit5 framing error, bit6 CTS asserted, bit7 DSR asserted (dsr_n low), and bit3 is 0.
- R4: A frame on txd is one 0 start bit, eight data bits LSB first and one 1 stop bit. Each bit lasts 16 baud ticks, and the line idles at 1.
- R5: A held byte starts to transmit only while command bit 0 is 1 and cts_n is 0.
- R6: A data write (cd_sel=0) clears tx_rdy. tx_rdy returns to 1 when the byte moves into the shift register. tx_empty is 0 from that move until the stop bit has ended.
- R7: A second byte can be written while the first is shifting. The two frames are sent back to back in write order.
- R8: A received byte sets rx_rdy and is read with cd_sel=0. That read clears rx_rdy.
- R9: A low pulse on rxd that has ended before mid start bit (8 ticks) does not start a reception.
- R10: A byte that completes while rx_rdy is 1 replaces the buffer and sets the overrun status bit.
- R11: A stop bit sampled as 0 sets the framing error status bit. A command write with bit 4 set clears both error bits.
- R12: A data write in the same cycle that the holding register moves into the shift register keeps the new byte: tx_rdy stays 0 and both bytes are sent in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select, active low |
| cd_sel | input | 1 | 1 = command/status, 0 = data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, one cycle per write |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when no read is selected |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| dsr_n | input | 1 | Modem data-set-ready, active low |
| cts_n | input | 1 | Modem clear-to-send, active low |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| tx_rdy | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding and shift path idle at the shifter |
| rx_rdy | output | 1 | Receive buffer holds an unread byte |

## Verification
Two things can fall in the same cycle: a processor write to the holding register and the move of that register's old byte into the shift register. The bench provokes this with a queued byte and the transmitter disabled. It then issues back-to-back writes, a command write that enables transmission and then, in the very next cycle, a data write. The result is judged by tx_rdy staying low and tx_empty going low, and then by capturing both frames on txd in write order.

// File: rtl/sio_xcvr.sv
module sio_xcvr #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       cd_sel,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic       baud_tick,
  input  logic       rxd,
  output logic       txd,
  input  logic       dsr_n,
  input  logic       cts_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       tx_rdy,
  output logic       tx_empty,
  output logic       rx_rdy
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF - 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_e;

  wire sel    = ~cs_n;
  wire wr_cmd = sel & ~wr_n & cd_sel;
  wire wr_dat = sel & ~wr_n & ~cd_sel;
  wire rd_dat = sel & ~rd_n & ~cd_sel;
  wire err_clr = wr_cmd & din[4];

  logic [7:0] cmd;
  always_ff @(posedge clk) begin
    if (rst) cmd <= '0;
    else if (wr_cmd) cmd <= din & 8'hEF;
  end
  assign dtr_n = ~cmd[1];
  assign rts_n = ~cmd[5];

  // transmit path
  logic [7:0]    thr;
  logic          thr_full;
  logic          tx_busy;
  logic [9:0]    tx_sh;
  logic [3:0]    tx_bits;
  logic [CW-1:0] tx_cnt;

  wire tx_load = thr_full & ~tx_busy & cmd[0] & ~cts_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr      <= '0;
      thr_full <= 1'b0;
      tx_busy  <= 1'b0;
      tx_sh    <= '1;
      tx_bits  <= '0;
      tx_cnt   <= '0;
    end else begin
      if (wr_dat) thr <= din;
      if (wr_dat) thr_full <= 1'b1;
      else if (tx_load) thr_full <= 1'b0;
      if (tx_load) begin
        tx_sh   <= {1'b1, thr, 1'b0};
        tx_busy <= 1'b1;
        tx_bits <= 4'd10;
        tx_cnt  <= '0;
      end else if (tx_busy && baud_tick) begin
        if (tx_cnt == LAST) begin
          tx_cnt  <= '0;
          tx_sh   <= {1'b1, tx_sh[9:1]};
          tx_bits <= tx_bits - 4'd1;
          if (tx_bits == 4'd1) tx_busy <= 1'b0;
        end else begin
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
    end
  end

  assign txd      = tx_busy ? tx_sh[0] : 1'b1;
  assign tx_rdy   = ~thr_full;
  assign tx_empty = ~tx_busy;

  // receive path
  logic [1:0]    rx_sync;
  logic          rx_prev;
  rx_st_e        rx_st;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_bit;
  logic [7:0]    rx_sh;
  logic [7:0]    rx_buf;
  logic          rx_full, ovr, ferr;

  wire rx_in   = rx_sync[1];
  wire rx_done = baud_tick & (rx_st == R_STOP) & (rx_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= 2'b11;
    else rx_sync <= {rx_sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_prev <= 1'b1;
      rx_st   <= R_IDLE;
      rx_cnt  <= '0;
      rx_bit  <= '0;
      rx_sh   <= '0;
    end else if (baud_tick) begin
      rx_prev <= rx_in;
      case (rx_st)
        R_IDLE: if (rx_prev && !rx_in) begin
          rx_st  <= R_START;
          rx_cnt <= '0;
        end
        R_START: if (rx_cnt == MID) begin
          rx_cnt <= '0;
          rx_bit <= '0;
          rx_st  <= rx_in ? R_IDLE : R_DATA;
        end else rx_cnt <= rx_cnt + 1'b1;
        R_DATA: if (rx_cnt == LAST) begin
          rx_cnt <= '0;
          rx_sh  <= {rx_in, rx_sh[7:1]};
          rx_bit <= rx_bit + 3'd1;
          if (rx_bit == 3'd7) rx_st <= R_STOP;
        end else rx_cnt <= rx_cnt + 1'b1;
        default: if (rx_cnt == LAST) begin
          rx_cnt <= '0;
          rx_st  <= R_IDLE;
        end else rx_cnt <= rx_cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      if (rx_done) rx_buf <= rx_sh;
      if (rx_done) rx_full <= 1'b1;
      else if (rd_dat) rx_full <= 1'b0;
      if (rx_done && rx_full && !rd_dat) ovr <= 1'b1;
      else if (err_clr) ovr <= 1'b0;
      if (rx_done && !rx_in) ferr <= 1'b1;
      else if (err_clr) ferr <= 1'b0;
    end
  end

  assign rx_rdy = rx_full;

  wire [7:0] status = {~dsr_n, ~cts_n, ferr, ovr, 1'b0, tx_empty, rx_full, tx_rdy};
  assign dout = (sel & ~rd_n) ? (cd_sel ? status : rx_buf) : 8'h00;
endmodule

// File: rtl/sio_xcvr_chk.sv
module sio_xcvr_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       cd_sel,
  input logic       wr_n,
  input logic [7:0] dout,
  input logic       txd,
  input logic       cts_n,
  input logic       dtr_n,
  input logic       tx_rdy,
  input logic       tx_empty
);
  a_r2_unselected_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> dout == 8'h00);

  a_r3_dtr_only_by_cmd: assert property (@(posedge clk) disable iff (rst)
    !(!cs_n && !wr_n && cd_sel) |=> $stable(dtr_n));

  a_r4_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd);

  a_r5_cts_holds_off: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && cts_n) |=> tx_empty);

  a_r6_write_takes_buffer: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && !cd_sel) |=> !tx_rdy);
endmodule

bind sio_xcvr sio_xcvr_chk chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .cd_sel(cd_sel), .wr_n(wr_n),
  .dout(dout), .txd(txd), .cts_n(cts_n), .dtr_n(dtr_n),
  .tx_rdy(tx_rdy), .tx_empty(tx_empty)
);

// File: tb/sio_xcvr_tb_top.sv
module sio_xcvr_tb_top;
  logic clk = 0, rst = 1;
  logic cs_n = 1, cd_sel = 0, rd_n = 1, wr_n = 1;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic baud_tick = 0, rxd = 1, dsr_n = 1, cts_n = 1;
  logic txd, dtr_n, rts_n, tx_rdy, tx_empty, rx_rdy;
  int n_run = 0, n_fail = 0;
  localparam int BIT = 64;

  always #2 clk = ~clk;

  sio_xcvr dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cd_sel(cd_sel), .rd_n(rd_n),
    .wr_n(wr_n), .din(din), .dout(dout), .baud_tick(baud_tick),
    .rxd(rxd), .txd(txd), .dsr_n(dsr_n), .cts_n(cts_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .tx_rdy(tx_rdy),
    .tx_empty(tx_empty), .rx_rdy(rx_rdy)
  );

  initial begin
    forever begin
      @(negedge clk) baud_tick = 1;
      @(negedge clk) baud_tick = 0;
      repeat (2) @(negedge clk);
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic acc_wr(input logic cs, input logic cd, input logic [7:0] d);
    cs_n = ~cs; cd_sel = cd; din = d; wr_n = 0;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic acc_rd(input logic cs, input logic cd, output logic [7:0] d);
    cs_n = ~cs; cd_sel = cd; rd_n = 0;
    #1 d = dout;
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    rxd = 0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (BIT) @(negedge clk); end
    rxd = stop; repeat (BIT) @(negedge clk);
    rxd = 1; repeat (BIT) @(negedge clk);
  endtask

  task automatic cap_tx(output logic [7:0] b, output logic ok);
    int n = 0;
    ok = 1; b = 0;
    while (txd !== 1'b0 && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) ok = 0;
    repeat (BIT / 2) @(negedge clk);
    if (txd !== 1'b0) ok = 0;
    for (int i = 0; i < 8; i++) begin repeat (BIT) @(negedge clk); b[i] = txd; end
    repeat (BIT) @(negedge clk);
    if (txd !== 1'b1) ok = 0;
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk(txd, 1, "R1 txd idle");
    chk(tx_rdy, 1, "R1 tx_rdy");
    chk(tx_empty, 1, "R1 tx_empty");
    chk(rx_rdy, 0, "R1 rx_rdy");
    chk({dtr_n, rts_n}, 2'b11, "R1 modem outs");
    acc_rd(1, 1, s);
    chk(s, 8'h05, "R3 status after reset");
  endtask

  task automatic t_select;
    logic [7:0] s;
    acc_wr(0, 0, 8'h55);
    acc_wr(0, 1, 8'h22);
    @(negedge clk);
    chk(tx_rdy, 1, "R2 unselected data write");
    chk(dtr_n, 1, "R2 unselected cmd write");
    acc_rd(0, 1, s);
    chk(s, 0, "R2 unselected read");
  endtask

  task automatic t_cmd;
    logic [7:0] s;
    acc_wr(1, 1, 8'h22);
    chk({dtr_n, rts_n}, 2'b00, "R3 dtr/rts driven");
    dsr_n = 0; cts_n = 0;
    acc_rd(1, 1, s);
    chk(s, 8'hC5, "R3 status modem bits");
    acc_wr(1, 1, 8'h00);
    chk({dtr_n, rts_n}, 2'b11, "R3 dtr/rts released");
  endtask

  task automatic t_gate;
    logic [7:0] b; logic ok; int lows = 0;
    cts_n = 0;
    acc_wr(1, 0, 8'hA5);
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd) lows++; end
    chk(lows, 0, "R5 disabled no start");
    chk({tx_rdy, tx_empty}, 2'b01, "R5 byte held");
    cts_n = 1;
    acc_wr(1, 1, 8'h01);
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd) lows++; end
    chk(lows, 0, "R5 cts high no start");
    cts_n = 0;
    cap_tx(b, ok);
    chk(ok, 1, "R4 frame shape");
    chk(b, 8'hA5, "R4 frame data");
    repeat (BIT) @(negedge clk);
    chk({tx_rdy, tx_empty}, 2'b11, "R6 idle after stop");
  endtask

  task automatic t_double;
    logic [7:0] b; logic ok;
    acc_wr(1, 0, 8'h3C);
    repeat (3) @(negedge clk);
    chk({tx_rdy, tx_empty}, 2'b10, "R6 moved to shifter");
    acc_wr(1, 0, 8'hC3);
    chk({tx_rdy, tx_empty}, 2'b00, "R7 second byte held");
    cap_tx(b, ok);
    chk({ok, b}, {1'b1, 8'h3C}, "R7 first frame");
    cap_tx(b, ok);
    chk({ok, b}, {1'b1, 8'hC3}, "R7 second frame");
    repeat (BIT) @(negedge clk);
    chk({tx_rdy, tx_empty}, 2'b11, "R6 empty after both");
  endtask

  task automatic t_collide;
    logic [7:0] b; logic ok;
    acc_wr(1, 1, 8'h00);
    acc_wr(1, 0, 8'h5A);
    acc_wr(1, 1, 8'h01);
    acc_wr(1, 0, 8'h81);
    chk({tx_rdy, tx_empty}, 2'b00, "R12 write during move kept");
    cap_tx(b, ok);
    chk({ok, b}, {1'b1, 8'h5A}, "R12 first frame");
    cap_tx(b, ok);
    chk({ok, b}, {1'b1, 8'h81}, "R12 second frame");
    repeat (BIT) @(negedge clk);
  endtask

  task automatic t_rx;
    logic [7:0] d;
    send_rx(8'h96, 1);
    chk(rx_rdy, 1, "R8 rx_rdy set");
    acc_rd(1, 0, d);
    chk(d, 8'h96, "R8 received byte");
    chk(rx_rdy, 0, "R8 read clears");
  endtask

  task automatic t_glitch;
    rxd = 0; repeat (16) @(negedge clk);
    rxd = 1; repeat (800) @(negedge clk);
    chk(rx_rdy, 0, "R9 short low rejected");
  endtask

  task automatic t_errors;
    logic [7:0] d;
    send_rx(8'h11, 1);
    send_rx(8'h22, 1);
    acc_rd(1, 1, d);
    chk(d[4], 1, "R10 overrun flag");
    acc_rd(1, 0, d);
    chk(d, 8'h22, "R10 newer byte kept");
    send_rx(8'h7E, 0);
    acc_rd(1, 1, d);
    chk({d[5], d[1]}, 2'b11, "R11 framing flag");
    acc_rd(1, 0, d);
    chk(d, 8'h7E, "R11 byte delivered");
    acc_wr(1, 1, 8'h11);
    acc_rd(1, 1, d);
    chk(d[5:4], 2'b00, "R11 error clear");
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_select();
    t_cmd();
    t_gate();
    t_double();
    t_collide();
    t_rx();
    t_glitch();
    t_errors();
    finish_run();
  end
endmodule